// File: doc/BRIEF.md
# Ping-pong receive DMA status tracker

This block keeps the status picture for a serial port whose receive DMA fills two memory buffers, A and B, in turn from a receive FIFO. Every byte the DMA takes from the FIFO arrives with frame, parity and overrun tags. The tracker charges each tag to the buffer that was filling when the byte was taken. It also shows which receive and transmit buffers are active. For SPI slave operation it records slave-select deassertions, which buffer's byte count was captured, and whether the line deasserted once or more than once.

The bus master, the FIFO and the shift logic are not part of this block. Strobes, tags, a byte counter and the slave-select line stand in for them at the ports. Software reads one 32-bit status word and one saved-count register. A receive DMA reset clears all receive-side state and leaves the transmit indications as they are.

Top module: `pp_rxdma_status`

## Requirements
- R1: After the synchronous reset `rst`, `status` and `saved_cnt` read zero. `status[31:13]` always reads zero.
- R2: `status[0]` (buffer A) and `status[1]` (buffer B) go high the cycle after that buffer's load strobe and low the cycle after its unload strobe. `status[2]` and `status[3]` show `tx_act_a` and `tx_act_b` one cycle late.
- R3: The filling buffer is A after reset and after a receive DMA reset. An unload strobe for the filling buffer hands filling to the other buffer. A byte popped from the FIFO (`fifo_pop`) is charged to the filling buffer.
- R4: Frame-error flags, A in `status[8]` and B in `status[9]`, set when the buffer takes a byte with `fifo_frame_err` while `uart_mode`=1. They clear on that buffer's next load. In SPI mode they do not change, except to clear on a load.
- R5: Parity-error flags, A in `status[6]` and B in `status[7]`, follow the same set, clear and UART-only rules as R4, using `fifo_par_err`.
- R6: Overrun flags, A in `status[4]` and B in `status[5]`, set in either mode when the buffer takes a byte tagged `fifo_ovr`. After both buffers have been unloaded, this is the buffer due to load next. They clear on that buffer's next load.
- R7: When a buffer is loaded and takes an error-tagged byte in the same cycle, the flag ends up set.
- R8: `dma_rst` clears `status[1:0]`, `status[12:4]` and `saved_cnt`, and returns filling to A. `status[3:2]` are not affected.
- R9: In SPI mode (`uart_mode`=0), the first rising edge of `ssel_n` after a load writes code 2 (buffer A filling) or code 3 (buffer B filling) into `status[12:10]`. The same edge captures `byte_cnt` into `saved_cnt`.
- R10: Later rising edges before the next load set `status[12]`, giving code 6 or 7. They leave `saved_cnt` unchanged.
- R11: Any load clears `status[12:10]`, unless that same cycle holds a rising edge, which then writes a fresh code 2 or 3. Edges in UART mode are ignored. Codes 1, 4 and 5 never appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dma_rst | input | 1 | Receive DMA reset |
| uart_mode | input | 1 | 1 = UART, 0 = SPI slave |
| load_a | input | 1 | Receive buffer A load strobe |
| load_b | input | 1 | Receive buffer B load strobe |
| unload_a | input | 1 | Receive buffer A full or unloaded |
| unload_b | input | 1 | Receive buffer B full or unloaded |
| tx_act_a | input | 1 | Transmit buffer A active |
| tx_act_b | input | 1 | Transmit buffer B active |
| fifo_pop | input | 1 | DMA takes a byte from the FIFO this cycle |
| fifo_frame_err | input | 1 | Popped byte has a frame error |
| fifo_par_err | input | 1 | Popped byte has a parity error |
| fifo_ovr | input | 1 | Popped byte carries an overrun |
| byte_cnt | input | CNT_W | Byte count of the filling buffer |
| ssel_n | input | 1 | Active-low slave select |
| status | output | 32 | Status word |
| saved_cnt | output | CNT_W | Captured receive count |

## Verification
Two pairs of functions can fall in one cycle. A load can coincide with an error-tagged byte for the same buffer, and a load can coincide with a slave-select deassertion edge. The bench drives the load strobe and `fifo_pop` with a frame or parity tag in the same cycle and expects the flag to end up set, while an older flag of the other kind is cleared. It then raises `ssel_n` in the cycle of a load and expects a fresh code 2 with the newly captured count. A stale or cleared field in that cycle counts as a failure.

// File: rtl/pp_rxstat_pkg.sv
package pp_rxstat_pkg;

    typedef enum logic {
        BUF_A = 1'b0,
        BUF_B = 1'b1
    } buf_sel_e;

    typedef struct packed {
        logic frame;
        logic parity;
        logic overrun;
    } err_flags_t;

    // Slave-select save field: {more, saved, which}
    typedef struct packed {
        logic more;
        logic saved;
        logic which;
    } save_code_t;

    localparam int STATUS_W = 32;
    localparam int USED_W   = 13;

    function automatic save_code_t fresh_code(buf_sel_e fill);
        save_code_t c;
        c.more  = 1'b0;
        c.saved = 1'b1;
        c.which = (fill == BUF_B);
        return c;
    endfunction

endpackage

// File: rtl/pp_buf_track.sv
module pp_buf_track
    import pp_rxstat_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       dma_rst,
    input  logic [1:0] load,
    input  logic [1:0] unload,
    input  logic [1:0] tx_in,
    output logic [1:0] rx_act,
    output logic [1:0] tx_act,
    output buf_sel_e   fill
);

    logic fill_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_act <= '0;
        end else begin
            tx_act <= tx_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || dma_rst) begin
            fill_q <= 1'b0;
        end else if (unload[fill_q]) begin
            fill_q <= ~fill_q;
        end
    end

    for (genvar i = 0; i < 2; i++) begin : g_act
        always_ff @(posedge clk) begin
            if (rst || dma_rst) begin
                rx_act[i] <= 1'b0;
            end else if (load[i]) begin
                rx_act[i] <= 1'b1;
            end else if (unload[i]) begin
                rx_act[i] <= 1'b0;
            end
        end

        assert_load_sets_act_R2: assert property (@(posedge clk) disable iff (rst)
            (load[i] && !dma_rst) |=> rx_act[i]);
        assert_unload_clears_act_R2: assert property (@(posedge clk) disable iff (rst)
            (unload[i] && !load[i]) |=> !rx_act[i]);
    end

    assign fill = buf_sel_e'(fill_q);

    assert_fill_handover_R3: assert property (@(posedge clk) disable iff (rst)
        (unload[fill_q] && !dma_rst) |=> (fill_q != $past(fill_q)));
    assert_dma_rst_rx_R8: assert property (@(posedge clk) disable iff (rst)
        dma_rst |=> (rx_act == 2'b00 && fill == BUF_A));

endmodule

// File: rtl/pp_err_flags.sv
module pp_err_flags
    import pp_rxstat_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       dma_rst,
    input  logic       uart_mode,
    input  logic       load,
    input  logic       take,
    input  err_flags_t tag,
    output err_flags_t flags
);

    err_flags_t set_now;

    always_comb begin
        set_now.frame   = take && tag.frame  && uart_mode;
        set_now.parity  = take && tag.parity && uart_mode;
        set_now.overrun = take && tag.overrun;
    end

    always_ff @(posedge clk) begin
        if (rst || dma_rst) begin
            flags <= '0;
        end else if (load) begin
            flags <= set_now;
        end else begin
            flags <= flags | set_now;
        end
    end

    assert_frame_sets_R4: assert property (@(posedge clk) disable iff (rst)
        (take && tag.frame && uart_mode && !dma_rst) |=> flags.frame);
    assert_spi_holds_R4: assert property (@(posedge clk) disable iff (rst)
        (!uart_mode && !load && !dma_rst) |=>
            (flags.frame == $past(flags.frame) && flags.parity == $past(flags.parity)));
    assert_parity_sets_R5: assert property (@(posedge clk) disable iff (rst)
        (take && tag.parity && uart_mode && !dma_rst) |=> flags.parity);
    assert_overrun_sets_R6: assert property (@(posedge clk) disable iff (rst)
        (take && tag.overrun && !dma_rst) |=> flags.overrun);
    assert_load_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (load && !take && !dma_rst) |=> (flags == '0));
    assert_dma_rst_flags_R8: assert property (@(posedge clk) disable iff (rst)
        dma_rst |=> (flags == '0));

endmodule

// File: rtl/pp_ssel_save.sv
module pp_ssel_save
    import pp_rxstat_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dma_rst,
    input  logic             uart_mode,
    input  logic             ssel_n,
    input  logic             any_load,
    input  buf_sel_e         fill,
    input  logic [CNT_W-1:0] byte_cnt,
    output save_code_t       code,
    output logic [CNT_W-1:0] saved_cnt
);

    logic ssel_q;
    logic rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            ssel_q <= 1'b1;
        end else begin
            ssel_q <= ssel_n;
        end
    end

    assign rise = ssel_n && !ssel_q && !uart_mode;

    always_ff @(posedge clk) begin
        if (rst || dma_rst) begin
            code      <= '0;
            saved_cnt <= '0;
        end else if (rise) begin
            if (any_load || !code.saved) begin
                code      <= fresh_code(fill);
                saved_cnt <= byte_cnt;
            end else begin
                code.more <= 1'b1;
            end
        end else if (any_load) begin
            code <= '0;
        end
    end

    assert_first_edge_R9: assert property (@(posedge clk) disable iff (rst)
        (rise && !code.saved && !dma_rst) |=>
            (code.saved && !code.more && saved_cnt == $past(byte_cnt)));
    assert_repeat_edge_R10: assert property (@(posedge clk) disable iff (rst)
        (rise && code.saved && !any_load && !dma_rst) |=>
            (code.more && saved_cnt == $past(saved_cnt)));
    assert_code_legal_R11: assert property (@(posedge clk) disable iff (rst)
        !(code == 3'd1 || code == 3'd4 || code == 3'd5));
    assert_load_clears_code_R11: assert property (@(posedge clk) disable iff (rst)
        (any_load && !rise && !dma_rst) |=> (code == '0));

endmodule

// File: rtl/pp_rxdma_status.sv
module pp_rxdma_status
    import pp_rxstat_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dma_rst,
    input  logic             uart_mode,
    input  logic             load_a,
    input  logic             load_b,
    input  logic             unload_a,
    input  logic             unload_b,
    input  logic             tx_act_a,
    input  logic             tx_act_b,
    input  logic             fifo_pop,
    input  logic             fifo_frame_err,
    input  logic             fifo_par_err,
    input  logic             fifo_ovr,
    input  logic [CNT_W-1:0] byte_cnt,
    input  logic             ssel_n,
    output logic [31:0]      status,
    output logic [CNT_W-1:0] saved_cnt
);

    logic [1:0] load_v;
    logic [1:0] unload_v;
    logic [1:0] rx_act;
    logic [1:0] tx_act;
    buf_sel_e   fill;
    err_flags_t tag;
    err_flags_t flg [2];
    save_code_t code;

    assign load_v   = {load_b, load_a};
    assign unload_v = {unload_b, unload_a};
    assign tag      = '{frame: fifo_frame_err, parity: fifo_par_err, overrun: fifo_ovr};

    pp_buf_track u_track (
        .clk    (clk),
        .rst    (rst),
        .dma_rst(dma_rst),
        .load   (load_v),
        .unload (unload_v),
        .tx_in  ({tx_act_b, tx_act_a}),
        .rx_act (rx_act),
        .tx_act (tx_act),
        .fill   (fill)
    );

    for (genvar i = 0; i < 2; i++) begin : g_buf
        pp_err_flags u_err (
            .clk      (clk),
            .rst      (rst),
            .dma_rst  (dma_rst),
            .uart_mode(uart_mode),
            .load     (load_v[i]),
            .take     (fifo_pop && (fill == buf_sel_e'(i))),
            .tag      (tag),
            .flags    (flg[i])
        );
    end

    pp_ssel_save #(.CNT_W(CNT_W)) u_ssel (
        .clk      (clk),
        .rst      (rst),
        .dma_rst  (dma_rst),
        .uart_mode(uart_mode),
        .ssel_n   (ssel_n),
        .any_load (|load_v),
        .fill     (fill),
        .byte_cnt (byte_cnt),
        .code     (code),
        .saved_cnt(saved_cnt)
    );

    assign status = {{(STATUS_W-USED_W){1'b0}}, code,
                     flg[1].frame,   flg[0].frame,
                     flg[1].parity,  flg[0].parity,
                     flg[1].overrun, flg[0].overrun,
                     tx_act, rx_act};

    assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (rst)
        status[31:13] == '0);

endmodule

// File: tb/sim_pp_rxdma_status.sv
`timescale 1ns/1ps
module sim_pp_rxdma_status;

    typedef struct packed {
        logic [3:0]  rq;
        logic [1:0]  ld;    // {b, a}
        logic [1:0]  ul;    // {b, a}
        logic        pop;
        logic        frm;
        logic        par;
        logic        ovr;
        logic        uart;
        logic        ssn;
        logic [7:0]  cnt;
        logic [12:0] est;
        logic [7:0]  ecnt;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t TBL [NV] = '{
        '{4'd2,  2'b01, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'd0,  13'h001,  8'd0}, // R2 load A
        '{4'd4,  2'b00, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'd0,  13'h101,  8'd0}, // R4 frame on A
        '{4'd5,  2'b00, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd0,  13'h141,  8'd0}, // R5 parity on A
        '{4'd2,  2'b10, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'd0,  13'h143,  8'd0}, // R2 load B
        '{4'd2,  2'b00, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'd0,  13'h142,  8'd0}, // R2 unload A
        '{4'd3,  2'b00, 2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'd0,  13'h3C2,  8'd0}, // R3 errors go to B
        '{4'd4,  2'b01, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'd0,  13'h283,  8'd0}, // R4 reload A clears A
        '{4'd3,  2'b00, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'd0,  13'h281,  8'd0}, // R3 unload B
        '{4'd3,  2'b00, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'd0,  13'h280,  8'd0}, // R3 both unloaded
        '{4'd6,  2'b10, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'd0,  13'h002,  8'd0}, // R6 B loads next
        '{4'd6,  2'b00, 2'b00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'd0,  13'h022,  8'd0}, // R6 overrun on B
        '{4'd4,  2'b00, 2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'd0,  13'h022,  8'd0}, // R4 SPI ignores tags
        '{4'd9,  2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd5,  13'h022,  8'd0}, // R9 select low
        '{4'd9,  2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'd7,  13'hC22,  8'd7}, // R9 code 3
        '{4'd10, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd9,  13'hC22,  8'd7}, // R10 low again
        '{4'd10, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'd11, 13'h1C22, 8'd7}, // R10 code 7
        '{4'd11, 2'b01, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'd0,  13'h023,  8'd7}, // R11 load clears
        '{4'd3,  2'b00, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'd0,  13'h021,  8'd7}, // R3 fill to A
        '{4'd9,  2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd3,  13'h021,  8'd7}, // R9 select low
        '{4'd9,  2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'd4,  13'h821,  8'd4}, // R9 code 2
        '{4'd11, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'd6,  13'h821,  8'd4}, // R11 UART low
        '{4'd11, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'd9,  13'h821,  8'd4}  // R11 UART edge ignored
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dma_rst = 1'b0;
    logic       uart_mode = 1'b1;
    logic       load_a = 1'b0, load_b = 1'b0, unload_a = 1'b0, unload_b = 1'b0;
    logic       tx_act_a = 1'b0, tx_act_b = 1'b0;
    logic       fifo_pop = 1'b0, fifo_frame_err = 1'b0, fifo_par_err = 1'b0, fifo_ovr = 1'b0;
    logic [7:0] byte_cnt = 8'd0;
    logic       ssel_n = 1'b1;
    logic [31:0] status;
    logic [7:0]  saved_cnt;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    pp_rxdma_status #(.CNT_W(8)) u0 (
        .clk(clk), .rst(rst), .dma_rst(dma_rst), .uart_mode(uart_mode),
        .load_a(load_a), .load_b(load_b), .unload_a(unload_a), .unload_b(unload_b),
        .tx_act_a(tx_act_a), .tx_act_b(tx_act_b),
        .fifo_pop(fifo_pop), .fifo_frame_err(fifo_frame_err),
        .fifo_par_err(fifo_par_err), .fifo_ovr(fifo_ovr),
        .byte_cnt(byte_cnt), .ssel_n(ssel_n),
        .status(status), .saved_cnt(saved_cnt)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 5000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=finish", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input int rq, input string what,
                         input logic [12:0] est, input logic [7:0] ecnt);
        logic [31:0] exp_s;
        exp_s = {19'b0, est};
        checks = checks + 1;
        if (status !== exp_s || saved_cnt !== ecnt) begin
            errors = errors + 1;
            $display("FAIL R%0d %s: actual status=%h cnt=%0d expected status=%h cnt=%0d",
                     rq, what, status, saved_cnt, exp_s, ecnt);
        end
    endtask

    task automatic apply(input vec_t v, input string what);
        @(negedge clk);
        load_b = v.ld[1];  load_a = v.ld[0];
        unload_b = v.ul[1]; unload_a = v.ul[0];
        fifo_pop = v.pop; fifo_frame_err = v.frm; fifo_par_err = v.par; fifo_ovr = v.ovr;
        uart_mode = v.uart; ssel_n = v.ssn; byte_cnt = v.cnt;
        @(posedge clk);
        #1;
        check(int'(v.rq), what, v.est, v.ecnt);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(1, "R1 reset state", 13'h000, 8'd0);

        for (int i = 0; i < NV; i++) begin
            apply(TBL[i], $sformatf("table step %0d", i));
        end

        // R8: receive DMA reset with transmit A going active
        @(negedge clk);
        dma_rst = 1'b1; tx_act_a = 1'b1;
        @(posedge clk); #1;
        check(8, "R8 dma reset keeps tx", 13'h004, 8'd0);
        @(negedge clk);
        dma_rst = 1'b0;

        // R7: load A and frame-tagged byte in same cycle
        apply('{4'd7, 2'b01, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'd0, 13'h105, 8'd0},
              "R7 load with frame byte");
        // R7: reload A with parity byte; old frame flag cleared
        apply('{4'd7, 2'b01, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd0, 13'h045, 8'd0},
              "R7 reload with parity byte");
        apply('{4'd9, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h10, 13'h045, 8'd0},
              "R9 select low in SPI");
        // R11: load and deassertion edge in same cycle give fresh code 2
        apply('{4'd11, 2'b01, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h33, 13'h805, 8'h33},
              "R11 load with select edge");
        apply('{4'd11, 2'b10, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h44, 13'h007, 8'h33},
              "R11 load B clears code");

        // R2: transmit indications follow one cycle late
        @(negedge clk);
        load_a = 1'b0; load_b = 1'b0; tx_act_a = 1'b0; tx_act_b = 1'b1;
        @(posedge clk); #1;
        check(2, "R2 tx B active", 13'h00B, 8'h33);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule